// File: doc/BRIEF.md
# Two-Mode Burst Address Sequencer

This block produces the two lowest address bits of a four-beat burst for a synchronous burst memory. A load strobe captures a full external address. The upper bits go to a register and are presented unchanged for the whole burst. The lowest bits become the start value of the burst. After that, each clock edge with the active-low advance input low moves the burst one beat forward. Advance high suspends the burst in place.

The order of the beats is fixed at reset by a static mode input. Linear order adds the beat number to the start value, modulo four. Interleaved order XORs the beat number into the start value. A free-running beat index holds the position in the burst, so both orders return to the start value after the fourth beat. A new strobe can arrive in the middle of a burst. It replaces the base address and starts the sequence again.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset (rst_n low) is sampled at a clock edge, `burst_lo_o` and `upper_o` read zero after that edge.
- R2: A clock edge with `load_i` high makes `burst_lo_o` equal to `addr_i[1:0]` and `upper_o` equal to `addr_i[ADDR_W-1:2]` after that edge.
- R3: With the order sampled as linear (mode input 0), beat n of a burst reads (start + n) mod 4.
- R4: With the order sampled as interleaved (mode input 1), beat n of a burst reads start XOR n.
- R5: A clock edge with `load_i` low and `adv_n_i` high leaves both `burst_lo_o` and `upper_o` unchanged.
- R6: After the fourth beat the sequence wraps. The beat after beat 3 reads the start value again, and beat 4+k reads the same as beat k.
- R7: A load during a burst replaces the start value and the upper bits, and the next beat is beat 1 of the new burst.
- R8: On an edge where `load_i` is high, `adv_n_i` is ignored. The output reads the start value (beat 0) even if `adv_n_i` is low.
- R9: The mode input is sampled only while reset is asserted. Later changes to it do not alter the order in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode input is also captured while it is low |
| mode_i | input | 1 | Order select: 0 linear, 1 interleaved; static |
| load_i | input | 1 | Address strobe; starts a new burst |
| addr_i | input | ADDR_W | Full external address, captured on a load |
| adv_n_i | input | 1 | Active-low advance; low steps the burst by one beat |
| burst_lo_o | output | CNT_W | Current burst address bits |
| upper_o | output | ADDR_W-CNT_W | Registered upper address bits |

## Verification
Two things can fall in the same edge. A strobe can arrive while advance is low, and a reload can happen in the middle of a burst when the index would otherwise step or wrap. The bench provokes the first by driving every load with advance low, then checks that the output reads the new start value and not its successor. It provokes the second by reloading after two beats with a different start value, then checks the next beats against the new start value, computed by arithmetic in both orders.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

endpackage

// File: rtl/bseq_mode_hold.sv
module bseq_mode_hold
  import burst_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mode_i,
  output order_e order_o
);

  order_e order_q;

  // captured only while reset is held; frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      order_q <= order_e'(mode_i);
    end
  end

  assign order_o = order_q;

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic             step_evt,
  output logic [CNT_W-1:0] idx_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] LAST_BEAT = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] next_beat(input logic [CNT_W-1:0] cur);
    return CNT_W'(cur + 1'b1);
  endfunction

  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (load_evt) begin
      idx_q <= '0;
    end else if (step_evt) begin
      idx_q <= next_beat(idx_q);
    end
  end

  assign idx_o  = idx_q;
  assign wrap_o = step_evt && (idx_q == LAST_BEAT);

endmodule

// File: rtl/bseq_base_reg.sv
module bseq_base_reg #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_evt,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [CNT_W-1:0]        base_o,
  output logic [ADDR_W-CNT_W-1:0] upper_o
);

  localparam int UP_W = ADDR_W - CNT_W;

  logic [CNT_W-1:0] base_q;
  logic [UP_W-1:0]  upper_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      upper_q <= '0;
    end else if (load_evt) begin
      base_q  <= addr_i[CNT_W-1:0];
      upper_q <= addr_i[ADDR_W-1:CNT_W];
    end
  end

  assign base_o  = base_q;
  assign upper_o = upper_q;

endmodule

// File: rtl/bseq_addr_form.sv
module bseq_addr_form
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] base_i,
  input  logic [CNT_W-1:0] idx_i,
  input  order_e           order_i,
  output logic [CNT_W-1:0] lo_o
);

  function automatic logic [CNT_W-1:0] lin_beat(input logic [CNT_W-1:0] b,
                                                input logic [CNT_W-1:0] n);
    return CNT_W'(b + n);
  endfunction

  function automatic logic [CNT_W-1:0] ilv_beat(input logic [CNT_W-1:0] b,
                                                input logic [CNT_W-1:0] n);
    return b ^ n;
  endfunction

  always_comb begin
    if (order_i == ORD_INTERLEAVE) begin
      lo_o = ilv_beat(base_i, idx_i);
    end else begin
      lo_o = lin_beat(base_i, idx_i);
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_i,
  input  logic                    load_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    adv_n_i,
  output logic [CNT_W-1:0]        burst_lo_o,
  output logic [ADDR_W-CNT_W-1:0] upper_o
);

  localparam int UP_W = ADDR_W - CNT_W;

  // named events, used by the bound checker
  logic             load_evt;
  logic             step_evt;
  logic             hold_evt;
  logic             wrap_evt;
  logic [CNT_W-1:0] beat_idx;
  logic [CNT_W-1:0] base_q;
  logic [UP_W-1:0]  upper_q;
  order_e           order_q;

  assign load_evt = load_i;
  assign step_evt = !load_i && !adv_n_i;   // load wins over advance
  assign hold_evt = !load_i && adv_n_i;

  bseq_mode_hold u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .order_o (order_q)
  );

  bseq_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .idx_o    (beat_idx),
    .wrap_o   (wrap_evt)
  );

  bseq_base_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .addr_i   (addr_i),
    .base_o   (base_q),
    .upper_o  (upper_q)
  );

  bseq_addr_form #(.CNT_W(CNT_W)) u_form (
    .base_i  (base_q),
    .idx_i   (beat_idx),
    .order_i (order_q),
    .lo_o    (burst_lo_o)
  );

  assign upper_o = upper_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    load_i,
  input logic                    adv_n_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [CNT_W-1:0]        burst_lo_o,
  input logic [ADDR_W-CNT_W-1:0] upper_o,
  input order_e                  order_q,
  input logic [CNT_W-1:0]        beat_idx,
  input logic [CNT_W-1:0]        base_q,
  input logic                    step_evt,
  input logic                    hold_evt,
  input logic                    wrap_evt
);

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (burst_lo_o == '0) && (upper_o == '0));

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (burst_lo_o == $past(addr_i[CNT_W-1:0]))
            && (upper_o == $past(addr_i[ADDR_W-1:CNT_W])));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && order_q == ORD_LINEAR)
      |=> burst_lo_o == CNT_W'($past(burst_lo_o) + 1'b1));

  assert_interleave_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && order_q == ORD_INTERLEAVE)
      |=> (burst_lo_o ^ $past(burst_lo_o))
          == ($past(beat_idx) ^ CNT_W'($past(beat_idx) + 1'b1)));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> $stable(burst_lo_o) && $stable(upper_o));

  assert_wrap_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (beat_idx == '0) && (burst_lo_o == base_q));

  assert_load_beats_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !adv_n_i) |=> beat_idx == '0);

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(order_q));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .adv_n_i    (adv_n_i),
  .addr_i     (addr_i),
  .burst_lo_o (burst_lo_o),
  .upper_o    (upper_o),
  .order_q    (order_q),
  .beat_idx   (beat_idx),
  .base_q     (base_q),
  .step_evt   (step_evt),
  .hold_evt   (hold_evt),
  .wrap_evt   (wrap_evt)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

  localparam int ADDR_W = 17;
  localparam int CNT_W  = 2;
  localparam int UP_W   = ADDR_W - CNT_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_i = 1'b0;
  logic              load_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              adv_n_i = 1'b1;
  logic [CNT_W-1:0]  burst_lo_o;
  logic [UP_W-1:0]   upper_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_burst_addr_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .load_i     (load_i),
    .addr_i     (addr_i),
    .adv_n_i    (adv_n_i),
    .burst_lo_o (burst_lo_o),
    .upper_o    (upper_o)
  );

  // expected beat n of a burst starting at s
  function automatic int beat_val(int s, int n, int ilv);
    if (ilv != 0) return s ^ (n % 4);
    return (s + n) % 4;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, the registers update at the posedge, sample at the next negedge
  task automatic cyc(bit ld, int addr, bit advn);
    load_i  = ld;
    addr_i  = ADDR_W'(addr);
    adv_n_i = advn;
    @(negedge clk);
  endtask

  task automatic run_mode(int ilv);
    string oreq;
    oreq = (ilv != 0) ? "R4" : "R3";
    rst_n  = 1'b0;
    mode_i = ilv[0];
    load_i = 1'b0;
    adv_n_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 lo", int'(burst_lo_o), 0);
    chk("R1 upper", int'(upper_o), 0);
    rst_n = 1'b1;
    mode_i = ~ilv[0];   // R9: must be ignored from now on
    for (int s = 0; s < 4; s++) begin
      int up;
      int cur;
      up = (s * 1237 + 91) % (1 << UP_W);
      // R8: load with advance asserted
      cyc(1'b1, (up << CNT_W) | s, 1'b0);
      chk("R2/R8 start", int'(burst_lo_o), s);
      chk("R2 upper", int'(upper_o), up);
      for (int n = 1; n <= 8; n++) begin
        cyc(1'b0, 0, 1'b0);
        chk((n >= 4) ? "R6 wrap" : {oreq, "/R9 order"}, int'(burst_lo_o), beat_val(s, n, ilv));
      end
      // R5: suspend for three cycles with address inputs changing
      cur = beat_val(s, 8, ilv);
      for (int h = 0; h < 3; h++) begin
        cyc(1'b0, 'h1ffff - h, 1'b1);
        chk("R5 hold lo", int'(burst_lo_o), cur);
        chk("R5 hold upper", int'(upper_o), up);
      end
      cyc(1'b0, 0, 1'b0);
      chk({oreq, " resume"}, int'(burst_lo_o), beat_val(s, 9, ilv));
      // R7: reload in the middle of a burst
      cyc(1'b0, 0, 1'b0);
      begin
        int s2;
        int up2;
        s2  = (s + 3) % 4;
        up2 = (up ^ 'h2a5a) % (1 << UP_W);
        cyc(1'b1, (up2 << CNT_W) | s2, 1'b0);
        chk("R7 restart", int'(burst_lo_o), s2);
        chk("R7 upper", int'(upper_o), up2);
        for (int n = 1; n <= 4; n++) begin
          cyc(1'b0, 0, 1'b0);
          chk("R7 new burst", int'(burst_lo_o), beat_val(s2, n, ilv));
        end
      end
      // mixed advance pattern: step, hold, step
      cyc(1'b1, (up << CNT_W) | s, 1'b1);
      chk("R2 reload", int'(burst_lo_o), s);
      cyc(1'b0, 0, 1'b0);
      cyc(1'b0, 0, 1'b1);
      chk("R5 mid hold", int'(burst_lo_o), beat_val(s, 1, ilv));
      cyc(1'b0, 0, 1'b0);
      chk({oreq, " after hold"}, int'(burst_lo_o), beat_val(s, 2, ilv));
    end
  endtask

  initial begin
    @(negedge clk);
    run_mode(0);
    run_mode(1);
    run_mode(0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule